// File: doc/BRIEF.md
# Four-Channel Shadowed PWM Controller

This block generates pulse-width modulated outputs on four independent channels, configured over a minimal memory-mapped register bus (address, write enable, write data, registered read data). Each channel carries its own period (range) register, active-length (duty) register and control register. A global control register holds one enable bit per channel and a commit bit.

Every register write lands in a staging copy first and does not change any output. Writing the commit bit hands the whole staged set (enables, modes, polarities, ranges and duties) to every channel at once. Each channel then adopts the new values at its next period boundary, so a waveform is never cut short in the middle of a period. A channel that is idle adopts them immediately. Only trailing-edge mark/space modulation is produced: the output is active for the first `duty` cycles of each `range`-cycle period.

Top module: `pwm_quad_ctrl`

## Requirements
- R1: Registers sit at fixed byte offsets: global control at 0x000, and for channel n (0..3) control at 0x014+16n, range at 0x018+16n, duty at 0x020+16n. A read returns the staged value of the addressed register in `bus_rdata` one clock after the address is presented. Range and duty are zero-extended.
- R2: Writing global control with bit 31 set commits the staged configuration. Bit 31 always reads back as 0, while the enable bits read back as written.
- R3: Writes to any register without a commit leave every output unchanged.
- R4: Global control bits [3:0] enable channels 0..3. A disabled channel drives its inactive level, which is 0, or 1 when its polarity bit is set.
- R5: Channel control bits [1:0] select the mode. Value 1 selects trailing-edge modulation. Values 0, 2 and 3 make the channel drive its inactive level.
- R6: An enabled channel in mode 1 with range R > 0 and duty D < R is active for the first D cycles of every R-cycle period. Starting from an idle channel, the first cycle of the first period appears on `pwm_o` in the third clock cycle after the edge that accepts the commit write.
- R7: Channel control bit 3 inverts that channel's output level in every state.
- R8: A duty greater than or equal to the range gives a constantly active output. A range of 0 gives a constantly inactive output.
- R9: A commit issued while a channel is running takes effect only after the last cycle of that channel's current period.
- R10: Channel control bit 8 is stored and read back but has no effect on the output.
- R11: After reset all registers read 0 and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (12) | Byte address of the register |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| pwm_o | output | NUM_CH (4) | One PWM output per channel |

## Verification
Read data is due one clock after the address is applied, so the bench presents the address on a falling edge and samples on the next falling edge. For a commit to an idle channel, the first output sample of the new period is due three rising edges after the write edge. The driver waits exactly those three edges and then queues one expected output vector per cycle, and a monitor pops and compares one vector on each falling edge. For a commit to a running channel, the driver queues the full remainder of the old period ahead of the new waveform, so the expected switch falls on the cycle after the old period's last cycle.

// File: rtl/pwm_quad_pkg.sv
package pwm_quad_pkg;

  localparam int DATA_W     = 32;
  localparam int COMMIT_BIT = 31;
  localparam int GLB_OFF    = 'h000;
  localparam int CTL_BASE   = 'h014;
  localparam int RNG_BASE   = 'h018;
  localparam int DTY_BASE   = 'h020;
  localparam int CH_STRIDE  = 16;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_TRAIL = 2'd1,
    MODE_RSV2  = 2'd2,
    MODE_RSV3  = 2'd3
  } mode_e;

  typedef struct packed {
    logic  spare;  // bit 8, storage only
    logic  pol;    // bit 3
    mode_e mode;   // bits [1:0]
  } ctl_t;

  function automatic int ctl_off(int n);
    return CTL_BASE + CH_STRIDE * n;
  endfunction

  function automatic int rng_off(int n);
    return RNG_BASE + CH_STRIDE * n;
  endfunction

  function automatic int dty_off(int n);
    return DTY_BASE + CH_STRIDE * n;
  endfunction

endpackage

// File: rtl/pwm_shadow_regs.sv
module pwm_shadow_regs
  import pwm_quad_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 12
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic                          bus_we,
  input  logic [DATA_W-1:0]             bus_wdata,
  output logic [DATA_W-1:0]             bus_rdata,
  output logic [NUM_CH-1:0]             stg_en,
  output ctl_t [NUM_CH-1:0]             stg_ctl,
  output logic [NUM_CH-1:0][CNT_W-1:0]  stg_range,
  output logic [NUM_CH-1:0][CNT_W-1:0]  stg_duty,
  output logic                          commit_o
);

  localparam logic [ADDR_W-1:0] GLB_A = ADDR_W'(GLB_OFF);

  logic              glb_hit;
  logic [DATA_W-1:0] rd_nxt;
  logic [DATA_W-1:0] rd_q;
  logic              commit_q;
  logic [NUM_CH-1:0] en_q;

  assign glb_hit = (bus_addr == GLB_A);

  // Global enables and the one-cycle commit strobe
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= '0;
      commit_q <= 1'b0;
    end else begin
      if (bus_we && glb_hit) en_q <= bus_wdata[NUM_CH-1:0];
      commit_q <= bus_we && glb_hit && bus_wdata[COMMIT_BIT];
    end
  end

  // Per-channel staging registers
  for (genvar n = 0; n < NUM_CH; n++) begin : g_stage
    localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(ctl_off(n));
    localparam logic [ADDR_W-1:0] RNG_A = ADDR_W'(rng_off(n));
    localparam logic [ADDR_W-1:0] DTY_A = ADDR_W'(dty_off(n));

    ctl_t             ctl_q;
    logic [CNT_W-1:0] rng_q;
    logic [CNT_W-1:0] dty_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        ctl_q <= '0;
        rng_q <= '0;
        dty_q <= '0;
      end else if (bus_we) begin
        if (bus_addr == CTL_A) begin
          ctl_q.mode  <= mode_e'(bus_wdata[1:0]);
          ctl_q.pol   <= bus_wdata[3];
          ctl_q.spare <= bus_wdata[8];
        end
        if (bus_addr == RNG_A) rng_q <= bus_wdata[CNT_W-1:0];
        if (bus_addr == DTY_A) dty_q <= bus_wdata[CNT_W-1:0];
      end
    end

    assign stg_ctl[n]   = ctl_q;
    assign stg_range[n] = rng_q;
    assign stg_duty[n]  = dty_q;
  end

  // Read mux over the staged copies
  always_comb begin
    rd_nxt = '0;
    if (glb_hit) rd_nxt[NUM_CH-1:0] = en_q;
    for (int n = 0; n < NUM_CH; n++) begin
      if (bus_addr == ADDR_W'(ctl_off(n))) begin
        rd_nxt[1:0] = stg_ctl[n].mode;
        rd_nxt[3]   = stg_ctl[n].pol;
        rd_nxt[8]   = stg_ctl[n].spare;
      end
      if (bus_addr == ADDR_W'(rng_off(n))) rd_nxt[CNT_W-1:0] = stg_range[n];
      if (bus_addr == ADDR_W'(dty_off(n))) rd_nxt[CNT_W-1:0] = stg_duty[n];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_nxt;
  end

  assign bus_rdata = rd_q;
  assign stg_en    = en_q;
  assign commit_o  = commit_q;

  // A read of global control never shows the commit bit (R2)
  assert_commit_reads_zero_R2: assert property (@(posedge clk) disable iff (rst)
    glb_hit |=> (bus_rdata[COMMIT_BIT] == 1'b0));

  // A commit strobe only follows a global write with bit 31 set (R2)
  assert_commit_source_R2: assert property (@(posedge clk) disable iff (rst)
    commit_o |-> $past(bus_we && glb_hit && bus_wdata[COMMIT_BIT]));

endmodule

// File: rtl/pwm_slice.sv
module pwm_slice
  import pwm_quad_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             commit_i,
  input  logic             cfg_en,
  input  ctl_t             cfg_ctl,
  input  logic [CNT_W-1:0] cfg_range,
  input  logic [CNT_W-1:0] cfg_duty,
  output logic             pwm_o
);

  // Committed values waiting for a period boundary
  logic             pend_valid;
  logic             pend_run;
  logic             pend_pol;
  logic [CNT_W-1:0] pend_range;
  logic [CNT_W-1:0] pend_duty;

  // Values the counter is running with
  logic             act_run;
  logic             act_pol;
  logic [CNT_W-1:0] act_range;
  logic [CNT_W-1:0] act_duty;
  logic [CNT_W-1:0] cnt;

  logic boundary;
  logic load;
  logic drive;
  logic pwm_q;
  logic unused_spare;

  assign unused_spare = cfg_ctl.spare;

  assign boundary = !act_run || (act_range == '0) || (cnt >= act_range - 1'b1);
  assign load     = boundary && pend_valid;
  assign drive    = act_run && (act_range != '0) && (cnt < act_duty);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_valid <= 1'b0;
      pend_run   <= 1'b0;
      pend_pol   <= 1'b0;
      pend_range <= '0;
      pend_duty  <= '0;
    end else if (commit_i) begin
      pend_valid <= 1'b1;
      pend_run   <= cfg_en && (cfg_ctl.mode == MODE_TRAIL);
      pend_pol   <= cfg_ctl.pol;
      pend_range <= cfg_range;
      pend_duty  <= cfg_duty;
    end else if (load) begin
      pend_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_run   <= 1'b0;
      act_pol   <= 1'b0;
      act_range <= '0;
      act_duty  <= '0;
      cnt       <= '0;
    end else if (load) begin
      act_run   <= pend_run;
      act_pol   <= pend_pol;
      act_range <= pend_range;
      act_duty  <= pend_duty;
      cnt       <= '0;
    end else if (boundary) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pwm_q <= 1'b0;
    else     pwm_q <= drive ^ act_pol;
  end

  assign pwm_o = pwm_q;

  // The counter never leaves the running period (R6)
  assert_cnt_in_period_R6: assert property (@(posedge clk) disable iff (rst)
    (act_run && act_range != '0) |-> (cnt < act_range));

  // An idle channel shows its polarity level on the next cycle (R4)
  assert_idle_level_R4: assert property (@(posedge clk) disable iff (rst)
    !act_run |=> (pwm_o == $past(act_pol)));

  // A zero range never drives the active level (R8)
  assert_zero_range_inactive_R8: assert property (@(posedge clk) disable iff (rst)
    (act_range == '0) |=> (pwm_o == $past(act_pol)));

  // Pending values wait for the period boundary (R9)
  assert_hold_to_boundary_R9: assert property (@(posedge clk) disable iff (rst)
    (pend_valid && !boundary) |=> ($stable(act_range) && $stable(act_duty) && $stable(act_pol)));

endmodule

// File: rtl/pwm_quad_ctrl.sv
module pwm_quad_ctrl
  import pwm_quad_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic [NUM_CH-1:0]  pwm_o
);

  logic [NUM_CH-1:0]             stg_en;
  ctl_t [NUM_CH-1:0]             stg_ctl;
  logic [NUM_CH-1:0][CNT_W-1:0]  stg_range;
  logic [NUM_CH-1:0][CNT_W-1:0]  stg_duty;
  logic                          commit;

  pwm_shadow_regs #(
    .NUM_CH (NUM_CH),
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .stg_en    (stg_en),
    .stg_ctl   (stg_ctl),
    .stg_range (stg_range),
    .stg_duty  (stg_duty),
    .commit_o  (commit)
  );

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    pwm_slice #(
      .CNT_W (CNT_W)
    ) u_slice (
      .clk       (clk),
      .rst       (rst),
      .commit_i  (commit),
      .cfg_en    (stg_en[n]),
      .cfg_ctl   (stg_ctl[n]),
      .cfg_range (stg_range[n]),
      .cfg_duty  (stg_duty[n]),
      .pwm_o     (pwm_o[n])
    );
  end

endmodule

// File: tb/test_pwm_quad_ctrl.sv
module test_pwm_quad_ctrl;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  pwm_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [3:0] exp;
    logic [3:0] mask;
    int         req;
  } item_t;

  item_t q[$];

  always #5 clk = ~clk;

  pwm_quad_ctrl i_pwm_quad_ctrl (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pwm_o     (pwm_o)
  );

  function automatic int ctl_a(int n); return 'h14 + 16 * n; endfunction
  function automatic int rng_a(int n); return 'h18 + 16 * n; endfunction
  function automatic int dty_a(int n); return 'h20 + 16 * n; endfunction

  function automatic logic wave(int j, int rng, int dty, bit pol);
    if (rng == 0) return pol;
    return logic'(((j % rng) < dty) ^ pol);
  endfunction

  // Monitor: one expected output vector per falling edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if ((pwm_o & it.mask) !== (it.exp & it.mask)) begin
        fails++;
        $display("FAIL R%0d: pwm_o actual %b expected %b (mask %b)",
                 it.req, pwm_o, it.exp, it.mask);
      end
    end
  end

  task automatic push(logic [3:0] e, logic [3:0] m, int r);
    item_t it;
    it.exp = e; it.mask = m; it.req = r;
    q.push_back(it);
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    bus_addr = 12'(a); bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_chk(int a, logic [31:0] e, string tag);
    @(negedge clk);
    bus_addr = 12'(a);
    @(negedge clk);
    checks++;
    if (bus_rdata !== e) begin
      fails++;
      $display("FAIL %s: read 0x%03h actual 0x%08h expected 0x%08h", tag, a, bus_rdata, e);
    end
  endtask

  // Commit with all channels disabled, then let every period run out
  task automatic go_idle();
    wr('h000, 32'h8000_0000);
    repeat (30) @(posedge clk);
  endtask

  // After a commit to idle channels, wait until the first output is due
  task automatic wait_first();
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R11: reset state
    checks++;
    if (pwm_o !== 4'b0000 || bus_rdata !== 32'h0) begin
      fails++;
      $display("FAIL R11: pwm_o/rdata actual %b/%h expected 0000/0", pwm_o, bus_rdata);
    end
    rd_chk('h000, 32'h0, "R11");
    rd_chk(rng_a(0), 32'h0, "R11");
    rd_chk(ctl_a(3), 32'h0, "R11");

    // R1/R10: stage distinct values, read them back
    wr(ctl_a(0), 32'h0000_0101);
    wr(rng_a(0), 32'd8);
    wr(dty_a(0), 32'd3);
    wr(ctl_a(1), 32'h0000_0009);
    wr(rng_a(1), 32'd5);
    wr(dty_a(1), 32'd2);
    wr(ctl_a(2), 32'h0000_0001);
    wr(rng_a(2), 32'd6);
    wr(dty_a(2), 32'd6);
    wr(ctl_a(3), 32'h0000_0001);
    wr(rng_a(3), 32'd0);
    wr(dty_a(3), 32'd4);
    rd_chk(ctl_a(0), 32'h0000_0101, "R10");
    rd_chk(rng_a(0), 32'd8, "R1");
    rd_chk(dty_a(0), 32'd3, "R1");
    rd_chk(ctl_a(1), 32'h0000_0009, "R1");
    rd_chk(rng_a(2), 32'd6, "R1");
    rd_chk(dty_a(3), 32'd4, "R1");

    // R3: nothing committed yet, outputs stay at reset level
    #1;
    for (int j = 0; j < 10; j++) push(4'b0000, 4'b1111, 3);
    drain();

    // R6 R7 R8 R10: commit all four from idle
    wr('h000, 32'h8000_000F);
    wait_first();
    for (int j = 0; j < 40; j++)
      push({1'b0, 1'b1, wave(j, 5, 2, 1'b1), wave(j, 8, 3, 1'b0)}, 4'b1111, 6);
    drain();
    rd_chk('h000, 32'h0000_000F, "R2");

    // R4: all disabled, each shows its polarity level
    go_idle();
    #1;
    for (int j = 0; j < 6; j++) push(4'b0010, 4'b1111, 4);
    drain();

    // R4: only channels 0 and 2 enabled
    wr('h000, 32'h8000_0005);
    wait_first();
    for (int j = 0; j < 24; j++)
      push({1'b0, 1'b1, 1'b1, wave(j, 8, 3, 1'b0)}, 4'b1111, 4);
    drain();

    // R5: mode 2 and mode 0 give the inactive level
    go_idle();
    wr(ctl_a(0), 32'h0000_0002);
    wr(ctl_a(2), 32'h0000_0000);
    wr('h000, 32'h8000_000F);
    wait_first();
    for (int j = 0; j < 20; j++)
      push({1'b0, 1'b0, wave(j, 5, 2, 1'b1), 1'b0}, 4'b1111, 5);
    drain();

    // R9: reconfigure channel 0 in the middle of a 20-cycle period
    go_idle();
    wr(ctl_a(0), 32'h0000_0001);
    wr(rng_a(0), 32'd20);
    wr(dty_a(0), 32'd5);
    wr('h000, 32'h8000_0001);
    wait_first();
    for (int j = 0; j < 20; j++) push({3'b000, wave(j, 20, 5, 1'b0)}, 4'b0001, 9);
    for (int j = 0; j < 24; j++) push({3'b000, wave(j, 4, 1, 1'b0)}, 4'b0001, 9);
    wr(rng_a(0), 32'd4);
    wr(dty_a(0), 32'd1);
    wr('h000, 32'h8000_0001);
    drain();
    rd_chk(rng_a(0), 32'd4, "R1");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule